// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the arithmetic and logic datapath of a small 8-bit processor core. Each cycle that `exec_i` is high, it applies one of sixteen operations to a register operand and a memory operand. The result is latched into `result_o`, and the Negative, Overflow, Zero and Carry flags in the status register are updated according to that operation's rules. Add and subtract run in plain binary, or in packed two-digit decimal when the Decimal flag is set.

Instruction decode, operand fetch and sequencing all live outside the block. The controller supplies the operation code and the two operands. Alongside the datapath sits a small status register. Separate set and clear strobes for Carry, Decimal, Interrupt-disable and Overflow let the controller force those bits directly. The register operand acts as the accumulator or index input, and the memory operand is the fetched byte.

Top module: `byte_alu_core`

## Requirements
- R1: Op 0 (add), with D=0, gives result = (reg + mem + C) mod 256. C is the carry out of bit 7, and V is set when both inputs share a sign that the result does not. N is result bit 7, and Z means the result is zero.
- R2: Op 1 (subtract), with D=0, gives result = (reg - mem - (1 - C)) mod 256. C=1 means no borrow occurred, and V is set when the inputs differ in sign and the result's sign differs from reg. N and Z follow the result.
- R3: With D=1, ops 0 and 1 treat each byte as two packed decimal digits and correct each digit by 6 (for example, 0x09 + 0x01 gives 0x10). C is the decimal carry, or for subtract the absence of a decimal borrow. N and Z come from the corrected result, and V is computed as in binary mode.
- R4: Ops 2 (AND), 3 (OR), 4 (XOR), 9 (reg + 1), 10 (reg - 1) and 15 (load: result = mem) update only N and Z. C and V keep their values.
- R5: Op 5 shifts reg left and op 6 shifts it right. The bit shifted out goes to C, the vacated end fills with 0, N and Z follow the result, and V is unchanged.
- R6: Op 7 rotates reg left and op 8 rotates it right, both through carry. The old C enters the vacated end, the bit shifted out becomes the new C, N and Z follow the result, and V is unchanged.
- R7: Op 11 (compare) leaves result = reg. It sets the flags as follows, and V is unchanged:
  - reg < mem (unsigned): N=1, Z=0, C=0.
  - reg = mem: N=0, Z=1, C=1.
  - reg > mem: N=0, Z=0, C=1.
- R8: Op 12 (bit test) leaves result = reg. Z is set when (reg AND mem) is zero, N takes mem bit 7, V takes mem bit 6, and C is unchanged.
- R9: Op 13 gives mem with bit `bit_sel_i` cleared, and op 14 gives mem with that bit set. Neither changes any status bit.
- R10: `flag_set_i` and `flag_clr_i` force status bits. Their bits map as follows: bit 0 is C, bit 1 is D, bit 2 is I and bit 3 is V. Set wins over clear, and either strobe overrides an ALU update of the same bit in the same cycle. D and I change only through these strobes.
- R11: `status_o` is {N, V, 1, 0, D, I, Z, C} from bit 7 down to bit 0. After reset it reads 0x24, with I=1 and every other flag 0.
- R12: `result_o` and the flags take their new values on the clock edge that samples `exec_i` high. With `exec_i` low, `result_o` holds its value. After reset it reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_i | input | 1 | Perform the operation this cycle |
| op_i | input | 4 | Operation code (see requirements) |
| bit_sel_i | input | 3 | Bit index for bit clear and bit set |
| reg_i | input | 8 | Register operand (accumulator or index) |
| mem_i | input | 8 | Memory operand |
| flag_set_i | input | 4 | Force-set strobes for C, D, I, V |
| flag_clr_i | input | 4 | Force-clear strobes for C, D, I, V |
| result_o | output | 8 | Registered result |
| status_o | output | 8 | Status byte N V 1 0 D I Z C |

## Verification
Some rules are checked by assertions on every cycle:
- A decimal add of valid digit operands yields valid digits.
- Compare never leaves Z set with C clear, and never leaves N and C set together.
- Bit clear and bit set leave the whole flag set untouched.
- Logic operations hold C and V.
- The force strobes win over ALU updates in the same cycle.

The exact arithmetic is shown only by the bench's scenarios. These cover:
- Carries, overflows and decimal digit corrections across large operand sweeps, with both carry-in values.
- Shift and rotate fill bits.
- Compare ordering at the extremes.
- Result holding while idle.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_SHL  = 4'd5,
    OP_SHR  = 4'd6,
    OP_ROL  = 4'd7,
    OP_ROR  = 4'd8,
    OP_INC  = 4'd9,
    OP_DEC  = 4'd10,
    OP_CMP  = 4'd11,
    OP_BIT  = 4'd12,
    OP_BCLR = 4'd13,
    OP_BSET = 4'd14,
    OP_LOAD = 4'd15
  } alu_op_e;

  // bit positions inside the force strobes
  localparam int CTL_C = 0;
  localparam int CTL_D = 1;
  localparam int CTL_I = 2;
  localparam int CTL_V = 3;
  localparam int CTL_W = 4;

  // bit positions inside the ALU update mask
  localparam int UPD_C = 0;
  localparam int UPD_Z = 1;
  localparam int UPD_V = 2;
  localparam int UPD_N = 3;

  typedef struct packed {
    logic n;
    logic v;
    logic d;
    logic i;
    logic z;
    logic c;
  } flags_t;

endpackage

// File: rtl/alu_dec_adder.sv
module alu_dec_adder #(
  parameter int DIGITS = 2
) (
  input  logic [4*DIGITS-1:0] a_i,
  input  logic [4*DIGITS-1:0] b_i,
  input  logic                sub_i,
  input  logic                dec_i,
  input  logic                carry_i,
  output logic [4*DIGITS-1:0] sum_o,
  output logic                carry_o,
  output logic                ovf_o
);
  localparam int W = 4 * DIGITS;

  // binary path: subtract is add of the inverted operand
  logic [W-1:0] b_eff;
  logic [W:0]   bin_sum;

  assign b_eff   = sub_i ? ~b_i : b_i;
  assign bin_sum = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, carry_i};
  assign ovf_o   = (a_i[W-1] == b_eff[W-1]) && (bin_sum[W-1] != a_i[W-1]);

  // decimal path: ripple of digit carries (add) or digit borrows (subtract)
  logic [DIGITS:0] chain;
  logic [W-1:0]    dec_sum;

  assign chain[0] = sub_i ? ~carry_i : carry_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [3:0] ad, bd;
    logic [4:0] s_add, s_sub;
    logic       fix_add, fix_sub;

    assign ad      = a_i[4*g +: 4];
    assign bd      = b_i[4*g +: 4];
    assign s_add   = {1'b0, ad} + {1'b0, bd} + {4'b0000, chain[g]};
    assign s_sub   = {1'b0, ad} - {1'b0, bd} - {4'b0000, chain[g]};
    assign fix_add = s_add > 5'd9;
    assign fix_sub = s_sub[4];

    assign dec_sum[4*g +: 4] = sub_i ? (fix_sub ? s_sub[3:0] - 4'd6 : s_sub[3:0])
                                     : (fix_add ? s_add[3:0] + 4'd6 : s_add[3:0]);
    assign chain[g+1] = sub_i ? fix_sub : fix_add;
  end

  assign sum_o   = dec_i ? dec_sum : bin_sum[W-1:0];
  assign carry_o = dec_i ? (sub_i ? ~chain[DIGITS] : chain[DIGITS]) : bin_sum[W];

endmodule

// File: rtl/alu_bit_unit.sv
module alu_bit_unit
  import byte_alu_pkg::*;
#(
  parameter int W = 8,
  localparam int SELW = $clog2(W)
) (
  input  alu_op_e         op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    m_i,
  input  logic            carry_i,
  input  logic [SELW-1:0] sel_i,
  output logic [W-1:0]    res_o,
  output logic            carry_o
);
  logic [W-1:0] mask;

  assign mask = {{(W-1){1'b0}}, 1'b1} << sel_i;

  always_comb begin
    res_o   = a_i;
    carry_o = carry_i;
    case (op_i)
      OP_AND:  res_o = a_i & m_i;
      OP_OR:   res_o = a_i | m_i;
      OP_XOR:  res_o = a_i ^ m_i;
      OP_INC:  res_o = a_i + {{(W-1){1'b0}}, 1'b1};
      OP_DEC:  res_o = a_i - {{(W-1){1'b0}}, 1'b1};
      OP_LOAD: res_o = m_i;
      OP_BCLR: res_o = m_i & ~mask;
      OP_BSET: res_o = m_i | mask;
      OP_SHL: begin
        res_o   = {a_i[W-2:0], 1'b0};
        carry_o = a_i[W-1];
      end
      OP_SHR: begin
        res_o   = {1'b0, a_i[W-1:1]};
        carry_o = a_i[0];
      end
      OP_ROL: begin
        res_o   = {a_i[W-2:0], carry_i};
        carry_o = a_i[W-1];
      end
      OP_ROR: begin
        res_o   = {carry_i, a_i[W-1:1]};
        carry_o = a_i[0];
      end
      default: begin
        res_o   = a_i;
        carry_o = carry_i;
      end
    endcase
  end

endmodule

// File: rtl/alu_flag_store.sv
module alu_flag_store
  import byte_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             exec_i,
  input  logic [3:0]       upd_i,
  input  logic             new_n_i,
  input  logic             new_v_i,
  input  logic             new_z_i,
  input  logic             new_c_i,
  input  logic [CTL_W-1:0] set_i,
  input  logic [CTL_W-1:0] clr_i,
  output flags_t           flags_o
);
  flags_t q;

  function automatic logic pick(input logic s, input logic cl, input logic ld,
                                input logic nv, input logic old);
    if (s)       return 1'b1;
    else if (cl) return 1'b0;
    else if (ld) return nv;
    else         return old;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '{n: 1'b0, v: 1'b0, d: 1'b0, i: 1'b1, z: 1'b0, c: 1'b0};
    end else begin
      q.n <= (exec_i && upd_i[UPD_N]) ? new_n_i : q.n;
      q.z <= (exec_i && upd_i[UPD_Z]) ? new_z_i : q.z;
      q.c <= pick(set_i[CTL_C], clr_i[CTL_C], exec_i && upd_i[UPD_C], new_c_i, q.c);
      q.v <= pick(set_i[CTL_V], clr_i[CTL_V], exec_i && upd_i[UPD_V], new_v_i, q.v);
      q.d <= pick(set_i[CTL_D], clr_i[CTL_D], 1'b0, 1'b0, q.d);
      q.i <= pick(set_i[CTL_I], clr_i[CTL_I], 1'b0, 1'b0, q.i);
    end
  end

  assign flags_o = q;

  // R10: a set strobe wins over clear and over an ALU carry update
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    set_i[CTL_C] |=> flags_o.c)
    else $error("carry set strobe lost");

  // R10: a lone clear strobe forces the decimal flag low
  assert_clear_decimal_R10: assert property (@(posedge clk) disable iff (rst)
    (clr_i[CTL_D] && !set_i[CTL_D]) |=> !flags_o.d)
    else $error("decimal clear strobe lost");

endmodule

// File: rtl/byte_alu_core.sv
module byte_alu_core
  import byte_alu_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W    = 4 * DIGITS,
  localparam int SELW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            exec_i,
  input  logic [3:0]      op_i,
  input  logic [SELW-1:0] bit_sel_i,
  input  logic [W-1:0]    reg_i,
  input  logic [W-1:0]    mem_i,
  input  logic [3:0]      flag_set_i,
  input  logic [3:0]      flag_clr_i,
  output logic [W-1:0]    result_o,
  output logic [7:0]      status_o
);
  alu_op_e op;
  flags_t  flags;

  assign op = alu_op_e'(op_i);

  // arithmetic unit
  logic [W-1:0] ar_res;
  logic         ar_c, ar_v;

  alu_dec_adder #(.DIGITS(DIGITS)) u_arith (
    .a_i     (reg_i),
    .b_i     (mem_i),
    .sub_i   (op == OP_SUB),
    .dec_i   (flags.d),
    .carry_i (flags.c),
    .sum_o   (ar_res),
    .carry_o (ar_c),
    .ovf_o   (ar_v)
  );

  // logic, shift, step and single-bit unit
  logic [W-1:0] bu_res;
  logic         bu_c;

  alu_bit_unit #(.W(W)) u_bits (
    .op_i    (op),
    .a_i     (reg_i),
    .m_i     (mem_i),
    .carry_i (flags.c),
    .sel_i   (bit_sel_i),
    .res_o   (bu_res),
    .carry_o (bu_c)
  );

  // result select and per-operation flag rules
  logic [W-1:0] res_n;
  logic         n_n, v_n, z_n, c_n;
  logic [3:0]   upd;

  always_comb begin
    res_n = reg_i;
    n_n   = 1'b0;
    z_n   = 1'b0;
    c_n   = flags.c;
    v_n   = flags.v;
    upd   = 4'b0000;
    case (op)
      OP_ADD, OP_SUB: begin
        res_n = ar_res;
        c_n   = ar_c;
        v_n   = ar_v;
        upd   = 4'b1111;
      end
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC, OP_LOAD: begin
        res_n = bu_res;
        upd[UPD_N] = 1'b1;
        upd[UPD_Z] = 1'b1;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        res_n = bu_res;
        c_n   = bu_c;
        upd[UPD_N] = 1'b1;
        upd[UPD_Z] = 1'b1;
        upd[UPD_C] = 1'b1;
      end
      OP_CMP: begin
        res_n = reg_i;
        n_n   = reg_i < mem_i;
        z_n   = reg_i == mem_i;
        c_n   = reg_i >= mem_i;
        upd[UPD_N] = 1'b1;
        upd[UPD_Z] = 1'b1;
        upd[UPD_C] = 1'b1;
      end
      OP_BIT: begin
        res_n = reg_i;
        n_n   = mem_i[W-1];
        v_n   = mem_i[W-2];
        z_n   = (reg_i & mem_i) == '0;
        upd[UPD_N] = 1'b1;
        upd[UPD_Z] = 1'b1;
        upd[UPD_V] = 1'b1;
      end
      OP_BCLR, OP_BSET: begin
        res_n = bu_res;
      end
      default: res_n = reg_i;
    endcase
    if (op != OP_CMP && op != OP_BIT) begin
      n_n = res_n[W-1];
      z_n = res_n == '0;
    end
  end

  alu_flag_store u_flags (
    .clk     (clk),
    .rst     (rst),
    .exec_i  (exec_i),
    .upd_i   (upd),
    .new_n_i (n_n),
    .new_v_i (v_n),
    .new_z_i (z_n),
    .new_c_i (c_n),
    .set_i   (flag_set_i),
    .clr_i   (flag_clr_i),
    .flags_o (flags)
  );

  logic [W-1:0] result_q;

  always_ff @(posedge clk) begin
    if (rst)         result_q <= '0;
    else if (exec_i) result_q <= res_n;
  end

  assign result_o = result_q;
  assign status_o = {flags.n, flags.v, 1'b1, 1'b0, flags.d, flags.i, flags.z, flags.c};

  function automatic logic digits_ok(input logic [W-1:0] x);
    for (int k = 0; k < DIGITS; k++)
      if (x[4*k +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  logic no_ctl;
  assign no_ctl = (flag_set_i == '0) && (flag_clr_i == '0);

  // R3: decimal add of valid digits gives valid digits
  assert_bcd_digits_R3: assert property (@(posedge clk) disable iff (rst)
    (exec_i && op == OP_ADD && flags.d && digits_ok(reg_i) && digits_ok(mem_i))
      |=> digits_ok(result_o))
    else $error("decimal add produced a non-decimal digit");

  // R4: logic and step operations keep carry and overflow
  assert_logic_keeps_cv_R4: assert property (@(posedge clk) disable iff (rst)
    (exec_i && no_ctl && (op == OP_AND || op == OP_OR || op == OP_XOR ||
                          op == OP_INC || op == OP_DEC || op == OP_LOAD))
      |=> $stable({flags.c, flags.v}))
    else $error("logic operation changed C or V");

  // R7: compare outcome is one of the three legal flag patterns
  assert_cmp_pattern_R7: assert property (@(posedge clk) disable iff (rst)
    (exec_i && no_ctl && op == OP_CMP)
      |=> ((!flags.z || flags.c) && !(flags.n && flags.c) && (flags.n || flags.c)))
    else $error("compare produced an illegal flag pattern");

  // R9: bit clear and bit set leave all flags alone
  assert_bitops_keep_flags_R9: assert property (@(posedge clk) disable iff (rst)
    (exec_i && no_ctl && (op == OP_BCLR || op == OP_BSET)) |=> $stable(flags))
    else $error("single-bit operation changed a flag");

endmodule

// File: tb/tb_byte_alu_core.sv
`timescale 1ns/1ps
module tb_byte_alu_core;

  localparam logic [3:0] K_ADD = 4'd0, K_SUB = 4'd1, K_AND = 4'd2, K_OR = 4'd3,
                         K_XOR = 4'd4, K_SHL = 4'd5, K_SHR = 4'd6, K_ROL = 4'd7,
                         K_ROR = 4'd8, K_INC = 4'd9, K_DEC = 4'd10, K_CMP = 4'd11,
                         K_BIT = 4'd12, K_BCLR = 4'd13, K_BSET = 4'd14, K_LOAD = 4'd15;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       exec_i = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic [2:0] bit_sel_i = 3'd0;
  logic [7:0] reg_i = 8'd0;
  logic [7:0] mem_i = 8'd0;
  logic [3:0] flag_set_i = 4'd0;
  logic [3:0] flag_clr_i = 4'd0;
  logic [7:0] result_o;
  logic [7:0] status_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] pre_st;

  always #2.5 clk = ~clk;

  byte_alu_core dut (
    .clk        (clk),
    .rst        (rst),
    .exec_i     (exec_i),
    .op_i       (op_i),
    .bit_sel_i  (bit_sel_i),
    .reg_i      (reg_i),
    .mem_i      (mem_i),
    .flag_set_i (flag_set_i),
    .flag_clr_i (flag_clr_i),
    .result_o   (result_o),
    .status_o   (status_o)
  );

  task automatic chk(input string rq, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] st(input logic n, input logic v, input logic d,
                                    input logic i, input logic z, input logic c);
    return {n, v, 1'b1, 1'b0, d, i, z, c};
  endfunction

  // preset C, D, V through the strobes, then execute one operation
  task automatic run_op(input logic [3:0] op, input logic [7:0] a, input logic [7:0] m,
                        input logic [2:0] sel, input logic c, input logic d, input logic v);
    @(negedge clk);
    exec_i     = 1'b0;
    flag_set_i = {v, 1'b0, d, c};
    flag_clr_i = {~v, 1'b0, ~d, ~c};
    @(negedge clk);
    pre_st     = status_o;
    flag_set_i = 4'd0;
    flag_clr_i = 4'd0;
    exec_i     = 1'b1;
    op_i       = op;
    reg_i      = a;
    mem_i      = m;
    bit_sel_i  = sel;
    @(negedge clk);
    exec_i     = 1'b0;
  endtask

  function automatic logic [7:0] to_bcd(input int x);
    return {4'(x / 10), 4'(x % 10)};
  endfunction

  task automatic arith_vec(input string rq, input bit sub, input bit dec,
                           input logic [7:0] a, input logic [7:0] b, input logic c);
    int s;
    logic [7:0] r, rb;
    logic co, vo;
    if (!sub) begin
      s  = int'(a) + int'(b) + int'(c);
      rb = 8'(s);
      vo = (a[7] == b[7]) && (rb[7] != a[7]);
    end else begin
      s  = int'(a) - int'(b) - (1 - int'(c));
      rb = 8'(s);
      vo = (a[7] != b[7]) && (rb[7] != a[7]);
    end
    if (!dec) begin
      r  = rb;
      co = sub ? (s >= 0) : (s > 255);
    end else begin
      int da, db, ds;
      da = int'(a[7:4]) * 10 + int'(a[3:0]);
      db = int'(b[7:4]) * 10 + int'(b[3:0]);
      if (!sub) begin
        ds = da + db + int'(c);
        co = ds > 99;
        if (ds > 99) ds = ds - 100;
      end else begin
        ds = da - db - (1 - int'(c));
        co = ds >= 0;
        if (ds < 0) ds = ds + 100;
      end
      r = to_bcd(ds);
    end
    run_op(sub ? K_SUB : K_ADD, a, b, 3'd0, c, dec, 1'b0);
    chk(rq, $sformatf("%s a=%h b=%h c=%0d", sub ? "sub" : "add", a, b, c),
        {result_o, status_o}, {r, st(r[7], vo, dec, 1'b1, r == 8'h00, co)});
  endtask

  task automatic t_reset();
    chk("R12", "result after reset", {8'h00, result_o}, {8'h00, 8'h00});
    chk("R11", "status after reset", {8'h00, status_o}, {8'h00, 8'h24});
  endtask

  task automatic t_add_binary();
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 17)
        for (int c = 0; c < 2; c++)
          arith_vec("R1", 1'b0, 1'b0, 8'(a), 8'(b), 1'(c));
  endtask

  task automatic t_sub_binary();
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 17)
        for (int c = 0; c < 2; c++)
          arith_vec("R2", 1'b1, 1'b0, 8'(a), 8'(b), 1'(c));
  endtask

  task automatic t_decimal();
    arith_vec("R3", 1'b0, 1'b1, 8'h09, 8'h01, 1'b0);
    arith_vec("R3", 1'b0, 1'b1, 8'h99, 8'h01, 1'b0);
    arith_vec("R3", 1'b1, 1'b1, 8'h00, 8'h01, 1'b1);
    arith_vec("R3", 1'b1, 1'b1, 8'h10, 8'h01, 1'b1);
    for (int a = 0; a < 100; a++)
      for (int b = 0; b < 100; b += 3)
        for (int c = 0; c < 2; c++) begin
          arith_vec("R3", 1'b0, 1'b1, to_bcd(a), to_bcd(b), 1'(c));
          arith_vec("R3", 1'b1, 1'b1, to_bcd(a), to_bcd(b), 1'(c));
        end
  endtask

  task automatic t_logic();
    logic [7:0] vals [8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h55, 8'hAA, 8'h3C};
    logic [3:0] ops  [6] = '{K_AND, K_OR, K_XOR, K_INC, K_DEC, K_LOAD};
    for (int o = 0; o < 6; o++)
      for (int i = 0; i < 8; i++)
        for (int cv = 0; cv < 4; cv++) begin
          logic [7:0] a, m, r;
          a = vals[i];
          m = vals[(i + 3) % 8];
          case (ops[o])
            K_AND:   r = a & m;
            K_OR:    r = a | m;
            K_XOR:   r = a ^ m;
            K_INC:   r = a + 8'd1;
            K_DEC:   r = a - 8'd1;
            default: r = m;
          endcase
          run_op(ops[o], a, m, 3'd0, cv[0], 1'b0, cv[1]);
          chk("R4", $sformatf("op=%0d a=%h m=%h", ops[o], a, m),
              {result_o, status_o}, {r, st(r[7], cv[1], 1'b0, 1'b1, r == 8'h00, cv[0])});
        end
  endtask

  task automatic t_shift();
    logic [7:0] vals [8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h55, 8'hAA, 8'h81};
    for (int o = 0; o < 4; o++)
      for (int i = 0; i < 8; i++)
        for (int c = 0; c < 2; c++) begin
          logic [7:0] a, r;
          logic co;
          logic [3:0] op;
          a = vals[i];
          case (o)
            0: begin op = K_SHL; r = {a[6:0], 1'b0};  co = a[7]; end
            1: begin op = K_SHR; r = {1'b0, a[7:1]};  co = a[0]; end
            2: begin op = K_ROL; r = {a[6:0], 1'(c)}; co = a[7]; end
            default: begin op = K_ROR; r = {1'(c), a[7:1]}; co = a[0]; end
          endcase
          run_op(op, a, 8'h00, 3'd0, 1'(c), 1'b0, 1'b1);
          chk(o < 2 ? "R5" : "R6", $sformatf("op=%0d a=%h c=%0d", op, a, c),
              {result_o, status_o}, {r, st(r[7], 1'b1, 1'b0, 1'b1, r == 8'h00, co)});
        end
  endtask

  task automatic t_compare();
    logic [7:0] ra [6] = '{8'h10, 8'h20, 8'h20, 8'h00, 8'hFF, 8'h80};
    logic [7:0] ma [6] = '{8'h20, 8'h20, 8'h10, 8'hFF, 8'h00, 8'h7F};
    for (int i = 0; i < 6; i++)
      for (int c = 0; c < 2; c++) begin
        run_op(K_CMP, ra[i], ma[i], 3'd0, 1'(c), 1'b0, 1'b1);
        chk("R7", $sformatf("cmp r=%h m=%h", ra[i], ma[i]), {result_o, status_o},
            {ra[i], st(ra[i] < ma[i], 1'b1, 1'b0, 1'b1, ra[i] == ma[i], ra[i] >= ma[i])});
      end
  endtask

  task automatic t_bit_test();
    logic [7:0] ra [4] = '{8'h0F, 8'hFF, 8'h01, 8'h80};
    logic [7:0] ma [4] = '{8'hF0, 8'h41, 8'h80, 8'h80};
    for (int i = 0; i < 4; i++)
      for (int c = 0; c < 2; c++) begin
        run_op(K_BIT, ra[i], ma[i], 3'd0, 1'(c), 1'b0, ~ma[i][6]);
        chk("R8", $sformatf("bit r=%h m=%h", ra[i], ma[i]), {result_o, status_o},
            {ra[i], st(ma[i][7], ma[i][6], 1'b0, 1'b1, (ra[i] & ma[i]) == 8'h00, 1'(c))});
      end
  endtask

  task automatic t_single_bits();
    logic [7:0] pats [3] = '{8'h00, 8'hFF, 8'h5A};
    for (int n = 0; n < 8; n++)
      for (int p = 0; p < 3; p++) begin
        run_op(K_BCLR, 8'h33, pats[p], 3'(n), n[0], 1'b0, n[1]);
        chk("R9", $sformatf("clear bit %0d of %h", n, pats[p]), {result_o, status_o},
            {pats[p] & ~(8'h01 << n), pre_st});
        run_op(K_BSET, 8'h33, pats[p], 3'(n), ~n[0], 1'b0, ~n[1]);
        chk("R9", $sformatf("set bit %0d of %h", n, pats[p]), {result_o, status_o},
            {pats[p] | (8'h01 << n), pre_st});
      end
  endtask

  task automatic t_hold();
    run_op(K_ADD, 8'h12, 8'h34, 3'd0, 1'b0, 1'b0, 1'b0);
    chk("R12", "result after exec", {8'h00, result_o}, {8'h00, 8'h46});
    for (int k = 0; k < 3; k++) begin
      op_i  = K_SUB;
      reg_i = 8'(k * 40 + 7);
      mem_i = 8'hC3;
      @(negedge clk);
      chk("R12", $sformatf("hold cycle %0d", k), {result_o, status_o},
          {8'h46, st(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0)});
    end
  endtask

  task automatic t_flag_controls();
    // clear I alone
    @(negedge clk);
    flag_clr_i = 4'b0100;
    @(negedge clk);
    flag_clr_i = 4'b0000;
    chk("R10", "I cleared", {15'd0, status_o[2]}, 16'd0);
    // set and clear together on D: set wins
    flag_set_i = 4'b0010;
    flag_clr_i = 4'b0010;
    @(negedge clk);
    flag_set_i = 4'b0000;
    flag_clr_i = 4'b0000;
    chk("R10", "D set wins", {15'd0, status_o[3]}, 16'd1);
    // leave decimal mode, then add with a carry-out while C is cleared the same cycle
    flag_clr_i = 4'b1011;
    @(negedge clk);
    exec_i     = 1'b1;
    op_i       = K_ADD;
    reg_i      = 8'hFF;
    mem_i      = 8'h01;
    flag_clr_i = 4'b0001;
    @(negedge clk);
    exec_i     = 1'b0;
    flag_clr_i = 4'b0000;
    chk("R10", "clear beats ALU carry", {result_o, status_o},
        {8'h00, st(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0)});
    // set V on the same cycle as a logic operation, set I back
    exec_i     = 1'b1;
    op_i       = K_AND;
    reg_i      = 8'hF0;
    mem_i      = 8'h90;
    flag_set_i = 4'b1100;
    @(negedge clk);
    exec_i     = 1'b0;
    flag_set_i = 4'b0000;
    chk("R10", "V and I set beside AND", {result_o, status_o},
        {8'h90, st(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0)});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R12 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_hold();
    t_add_binary();
    t_sub_binary();
    t_decimal();
    t_logic();
    t_shift();
    t_compare();
    t_bit_test();
    t_single_bits();
    t_flag_controls();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule